// File: doc/BRIEF.md
# Fail-Safe Clock Monitor

This block supervises an external oscillator from a slow sample clock that keeps running. At each test it sends a request across to the external clock domain and waits for the external clock to return it. If no answer arrives within a set number of sample cycles, the external clock is taken to have stopped. The block then raises a failure flag, enters a fail-safe state and steers the system clock select to the internal oscillator.

For crystal-type oscillator modes, a start-up timer counts external clock cycles after reset or wake-up. During that warm-up the system runs from the internal oscillator and failure detection is held off. For directly driven and RC modes, the external clock is used and monitored at once.

The fail-safe state is left only on a reset, on entry into sleep, or on a write to the clock-source-select bit. The failure flag cannot be cleared until the fail-safe state has ended. All control pins are plain level or single-cycle strobes in the sample clock domain, and `osc_mode` is held static between resets. The block has no data stream, so it has no valid/ready interface.

Top module: `clk_failsafe_mon`

## Requirements
- R1: `osc_mode` codes 0, 1 and 2 select the crystal modes. After reset or after `wake_up`, these modes hold `sys_clk_sel`=1 and `osc_stable`=0 until the start-up timer has counted OST_CYC external clock cycles, with a few synchroniser cycles added. After that, `sys_clk_sel`=0 and `osc_stable`=1, unless fail-safe or the source-select bit forces the internal clock.
- R2: `osc_mode` codes 3 to 7 are the direct and RC modes. In these modes `osc_stable`=1 and monitoring is active from the first cycle out of reset or sleep, with no start-up wait.
- R3: While the external clock runs at least twice as fast as the sample clock, no failure is declared. Once the external clock stops, a failure is declared within TMO_CYC+8 sample cycles.
- R4: A declared failure sets `fail_flag` and `failsafe` at the same sample edge. While `failsafe`=1, `sys_clk_sel`=1 (internal).
- R5: `failsafe` returns to 0 only through `rst_n`, a `sleep_enter` pulse, or a `src_sel_wr` pulse of either value. Restarting the external clock does not clear it, and neither does a flag clear.
- R6: A `freq_wr` pulse loads `freq_val` into `freq_cur` at the next sample edge. During fail-safe this does not end the fail-safe state.
- R7: `flag_clr` has no effect while `failsafe` is 1, judged on the state before the edge. This holds even when it arrives in the same cycle as an exit write. Once `failsafe` is 0, `flag_clr` clears `fail_flag` at the next edge.
- R8: No failure is declared while sleeping, or during the crystal-mode warm-up. This holds even when the external clock is stopped.
- R9: A `src_sel_wr` pulse stores `src_sel_val` as the source-select bit. A stored 1 forces `sys_clk_sel`=1.
- R10: While `rst_n`=0: `failsafe`=0, `fail_flag`=0, the source-select bit is 0, and `freq_cur`=FREQ_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Slow sample clock; all control logic runs on it |
| ext_clk | input | 1 | Monitored external oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_mode | input | 3 | Oscillator mode code (0-2 crystal, 3-7 direct/RC) |
| sleep_enter | input | 1 | Single-cycle sleep entry strobe |
| wake_up | input | 1 | Single-cycle wake strobe |
| src_sel_wr | input | 1 | Write strobe for the source-select bit |
| src_sel_val | input | 1 | Value written to the source-select bit (1 = internal) |
| freq_wr | input | 1 | Write strobe for the internal frequency code |
| freq_val | input | FREQ_W | Internal frequency code to load |
| flag_clr | input | 1 | Request to clear the failure flag |
| sys_clk_sel | output | 1 | System clock select (1 = internal oscillator) |
| fail_flag | output | 1 | Failure interrupt flag |
| failsafe | output | 1 | Fail-safe state active |
| osc_stable | output | 1 | External start-up and switchover complete |
| freq_cur | output | FREQ_W | Current internal frequency code |

## Verification
The hardest cases to reach are a stopped external clock that must not be reported, and a fail-safe exit that must not clear the flag. The bench halts the external clock in a crystal mode before the start-up timer can finish, and also while the block sleeps, then watches that `failsafe` stays low. It then causes a real failure and puts an exit write and a flag clear in the same cycle. It restarts the external clock before any exit, so the monitor does not see the failure again. A sweep over all eight mode codes, each with a fresh reset, checks the warm-up split at fixed points before and after the start-up window.

// File: rtl/fscm_pkg.sv
package fscm_pkg;

  typedef enum logic [2:0] {
    OSC_LP = 3'd0,
    OSC_XT = 3'd1,
    OSC_HS = 3'd2,
    OSC_EC = 3'd3,
    OSC_RC = 3'd4
  } osc_mode_e;

  // crystal-type modes need a start-up period before use
  function automatic logic needs_warmup(input logic [2:0] mode);
    return mode <= 3'(OSC_HS);
  endfunction

endpackage

// File: rtl/fscm_sync2.sv
module fscm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/fscm_ost.sv
module fscm_ost #(
  parameter int OST_CYC = 1024
) (
  input  logic ext_clk,
  input  logic rst_n,
  input  logic hold_smp,
  output logic done_ext
);
  localparam int CW = $clog2(OST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(OST_CYC);

  logic          hold_s;
  logic [CW-1:0] cnt;

  fscm_sync2 u_hold_sync (
    .clk  (ext_clk),
    .rst_n(rst_n),
    .d    (hold_smp),
    .q    (hold_s)
  );

  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      done_ext <= 1'b0;
    end else begin
      if (hold_s)           cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      done_ext <= (cnt == LAST);
    end
  end

  // R8: a hold request restarts the timer and drops completion
  p_ost_clear_r8: assert property (@(posedge ext_clk) disable iff (!rst_n)
    hold_s |-> ##2 !done_ext);
endmodule

// File: rtl/fscm_probe.sv
module fscm_probe #(
  parameter int TMO_CYC = 8
) (
  input  logic smp_clk,
  input  logic ext_clk,
  input  logic rst_n,
  output logic stale
);
  localparam int WW = $clog2(TMO_CYC + 1);
  localparam logic [WW-1:0] TMO = WW'(TMO_CYC);

  logic          req_tog;
  logic          req_x;
  logic          ack_tog;
  logic          ack_s;
  logic [WW-1:0] wait_cnt;
  logic          answered;

  // external domain echoes the request toggle back
  fscm_sync2 u_req_sync (
    .clk  (ext_clk),
    .rst_n(rst_n),
    .d    (req_tog),
    .q    (req_x)
  );

  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) ack_tog <= 1'b0;
    else        ack_tog <= req_x;
  end

  fscm_sync2 u_ack_sync (
    .clk  (smp_clk),
    .rst_n(rst_n),
    .d    (ack_tog),
    .q    (ack_s)
  );

  assign answered = (ack_s == req_tog);

  // a new test is issued each time the previous one is answered
  always_ff @(posedge smp_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tog  <= 1'b0;
      wait_cnt <= '0;
    end else if (answered) begin
      req_tog  <= ~req_tog;
      wait_cnt <= '0;
    end else if (wait_cnt != TMO) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assign stale = (wait_cnt == TMO);

  // R3: an unanswered test keeps the stale indication
  p_stale_exit_r3: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (stale && !answered) |=> stale);
endmodule

// File: rtl/fscm_ctrl.sv
module fscm_ctrl #(
  parameter int              FREQ_W   = 3,
  parameter logic [FREQ_W-1:0] FREQ_RST = '0
) (
  input  logic              smp_clk,
  input  logic              rst_n,
  input  logic [2:0]        osc_mode,
  input  logic              sleep_enter,
  input  logic              wake_up,
  input  logic              src_sel_wr,
  input  logic              src_sel_val,
  input  logic              freq_wr,
  input  logic [FREQ_W-1:0] freq_val,
  input  logic              flag_clr,
  input  logic              stale,
  input  logic              ost_done_s,
  output logic              sleeping,
  output logic              sys_clk_sel,
  output logic              fail_flag,
  output logic              failsafe,
  output logic              osc_stable,
  output logic [FREQ_W-1:0] freq_cur
);
  import fscm_pkg::*;

  logic warm;
  logic seen_low;
  logic ost_ok;
  logic armed;
  logic fail_det;
  logic scs;
  logic exit_req;

  assign warm     = needs_warmup(osc_mode);
  assign ost_ok   = seen_low & ost_done_s;
  assign armed    = !sleeping && (!warm || ost_ok);
  assign exit_req = sleep_enter | src_sel_wr;
  assign fail_det = armed & stale & !failsafe & !exit_req;

  always_ff @(posedge smp_clk or negedge rst_n) begin
    if (!rst_n) begin
      sleeping <= 1'b0;
      seen_low <= 1'b0;
    end else begin
      if (sleep_enter)  sleeping <= 1'b1;
      else if (wake_up) sleeping <= 1'b0;
      // a stale completion from before sleep must be seen low first
      if (sleep_enter || sleeping) seen_low <= 1'b0;
      else if (!ost_done_s)        seen_low <= 1'b1;
    end
  end

  always_ff @(posedge smp_clk or negedge rst_n) begin
    if (!rst_n) begin
      failsafe  <= 1'b0;
      fail_flag <= 1'b0;
      scs       <= 1'b0;
      freq_cur  <= FREQ_RST;
    end else begin
      if (exit_req)      failsafe <= 1'b0;
      else if (fail_det) failsafe <= 1'b1;

      if (fail_det)                  fail_flag <= 1'b1;
      else if (flag_clr && !failsafe) fail_flag <= 1'b0;

      if (src_sel_wr) scs      <= src_sel_val;
      if (freq_wr)    freq_cur <= freq_val;
    end
  end

  assign osc_stable  = armed;
  assign sys_clk_sel = failsafe | scs | (warm & !ost_ok);

  // R5: exit strobes always end the fail-safe state
  p_exit_r5: assert property (@(posedge smp_clk) disable iff (!rst_n)
    exit_req |=> !failsafe);
  // R7: clear request ignored during fail-safe
  p_flag_keep_r7: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (failsafe && flag_clr) |=> fail_flag);
  // R6: frequency change keeps fail-safe
  p_freq_stay_r6: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (failsafe && freq_wr && !exit_req) |=> failsafe);
  // R4: flag accompanies entry into fail-safe
  p_flag_with_fs_r4: assert property (@(posedge smp_clk) disable iff (!rst_n)
    $rose(failsafe) |-> fail_flag);
  // R4: fail-safe forces the internal clock
  p_sel_int_r4: assert property (@(posedge smp_clk) disable iff (!rst_n)
    failsafe |-> sys_clk_sel);
  // R8: no detection while sleeping
  p_quiet_sleep_r8: assert property (@(posedge smp_clk) disable iff (!rst_n)
    sleeping |=> !failsafe);
  // R1: crystal warm-up runs from the internal clock
  p_warm_sel_r1: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (warm && !osc_stable) |-> sys_clk_sel);
endmodule

// File: rtl/clk_failsafe_mon.sv
module clk_failsafe_mon #(
  parameter int              OST_CYC  = 1024,
  parameter int              TMO_CYC  = 8,
  parameter int              FREQ_W   = 3,
  parameter logic [FREQ_W-1:0] FREQ_RST = 3'd6
) (
  input  logic              smp_clk,
  input  logic              ext_clk,
  input  logic              rst_n,
  input  logic [2:0]        osc_mode,
  input  logic              sleep_enter,
  input  logic              wake_up,
  input  logic              src_sel_wr,
  input  logic              src_sel_val,
  input  logic              freq_wr,
  input  logic [FREQ_W-1:0] freq_val,
  input  logic              flag_clr,
  output logic              sys_clk_sel,
  output logic              fail_flag,
  output logic              failsafe,
  output logic              osc_stable,
  output logic [FREQ_W-1:0] freq_cur
);
  logic sleeping;
  logic stale;
  logic ost_done_x;
  logic ost_done_s;

  fscm_ost #(.OST_CYC(OST_CYC)) u_ost (
    .ext_clk (ext_clk),
    .rst_n   (rst_n),
    .hold_smp(sleeping),
    .done_ext(ost_done_x)
  );

  fscm_sync2 u_done_sync (
    .clk  (smp_clk),
    .rst_n(rst_n),
    .d    (ost_done_x),
    .q    (ost_done_s)
  );

  fscm_probe #(.TMO_CYC(TMO_CYC)) u_probe (
    .smp_clk(smp_clk),
    .ext_clk(ext_clk),
    .rst_n  (rst_n),
    .stale  (stale)
  );

  fscm_ctrl #(.FREQ_W(FREQ_W), .FREQ_RST(FREQ_RST)) u_ctrl (
    .smp_clk    (smp_clk),
    .rst_n      (rst_n),
    .osc_mode   (osc_mode),
    .sleep_enter(sleep_enter),
    .wake_up    (wake_up),
    .src_sel_wr (src_sel_wr),
    .src_sel_val(src_sel_val),
    .freq_wr    (freq_wr),
    .freq_val   (freq_val),
    .flag_clr   (flag_clr),
    .stale      (stale),
    .ost_done_s (ost_done_s),
    .sleeping   (sleeping),
    .sys_clk_sel(sys_clk_sel),
    .fail_flag  (fail_flag),
    .failsafe   (failsafe),
    .osc_stable (osc_stable),
    .freq_cur   (freq_cur)
  );
endmodule

// File: tb/clk_failsafe_mon_bench.sv
`timescale 1ns/1ps
module clk_failsafe_mon_bench;
  localparam int TMO = 8;
  localparam int FRST = 6;

  logic       smp_clk = 1'b0;
  logic       ext_clk = 1'b0;
  logic       ext_en = 1'b1;
  logic       rst_n = 1'b0;
  logic [2:0] osc_mode = 3'd3;
  logic       sleep_enter = 1'b0, wake_up = 1'b0;
  logic       src_sel_wr = 1'b0, src_sel_val = 1'b0;
  logic       freq_wr = 1'b0;
  logic [2:0] freq_val = 3'd0;
  logic       flag_clr = 1'b0;
  logic       sys_clk_sel, fail_flag, failsafe, osc_stable;
  logic [2:0] freq_cur;

  int checks = 0;
  int errors = 0;

  clk_failsafe_mon u_clk_failsafe_mon (
    .smp_clk(smp_clk), .ext_clk(ext_clk), .rst_n(rst_n), .osc_mode(osc_mode),
    .sleep_enter(sleep_enter), .wake_up(wake_up), .src_sel_wr(src_sel_wr),
    .src_sel_val(src_sel_val), .freq_wr(freq_wr), .freq_val(freq_val),
    .flag_clr(flag_clr), .sys_clk_sel(sys_clk_sel), .fail_flag(fail_flag),
    .failsafe(failsafe), .osc_stable(osc_stable), .freq_cur(freq_cur)
  );

  always #5 smp_clk = ~smp_clk;
  initial forever begin
    #2;
    if (ext_en) ext_clk = ~ext_clk;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge smp_clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] mode);
    @(negedge smp_clk);
    rst_n = 1'b0;
    osc_mode = mode;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic pulse_sleep();  sleep_enter = 1'b1; cyc(1); sleep_enter = 1'b0; endtask
  task automatic pulse_wake();   wake_up = 1'b1;     cyc(1); wake_up = 1'b0;     endtask

  task automatic write_src(input logic v, input logic clr);
    src_sel_wr = 1'b1; src_sel_val = v; flag_clr = clr;
    cyc(1);
    src_sel_wr = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    // R10: reset state
    @(negedge smp_clk);
    cyc(2);
    chk("R10 failsafe", failsafe, 0);
    chk("R10 flag", fail_flag, 0);
    chk("R10 freq", freq_cur, FRST);
    chk("R10 sel", sys_clk_sel, 0);
    rst_n = 1'b1;
    cyc(5);
    chk("R2 stable EC", osc_stable, 1);

    // R1 / R2 / R3: sweep of every mode code
    for (int m = 0; m < 8; m++) begin
      int bad;
      logic w;
      bad = 0;
      w = (m <= 2);
      do_reset(3'(m));
      for (int c = 0; c < 450; c++) begin
        cyc(1);
        if (failsafe) bad++;
        if (c == 50) begin
          chk(w ? "R1 early stable" : "R2 early stable", osc_stable, w ? 0 : 1);
          chk(w ? "R1 early sel" : "R2 early sel", sys_clk_sel, w ? 1 : 0);
        end
      end
      chk("R1 late stable", osc_stable, 1);
      chk("R1 late sel", sys_clk_sel, 0);
      chk("R3 no false failure", bad, 0);
    end

    // R3 / R4: failure detection in direct mode
    do_reset(3'd3);
    cyc(20);
    ext_en = 1'b0;
    cyc(2);
    chk("R3 not yet failed", failsafe, 0);
    cyc(TMO + 6);
    chk("R3 failsafe", failsafe, 1);
    chk("R4 flag", fail_flag, 1);
    chk("R4 sel internal", sys_clk_sel, 1);

    // R6: frequency change during fail-safe
    freq_val = 3'd2; freq_wr = 1'b1; cyc(1); freq_wr = 1'b0;
    chk("R6 freq", freq_cur, 2);
    chk("R6 still failsafe", failsafe, 1);

    // R7: clear ignored during fail-safe
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R7 flag kept", fail_flag, 1);
    chk("R5 clear no exit", failsafe, 1);

    // R5: restart does not exit; exit write with simultaneous clear
    ext_en = 1'b1;
    cyc(15);
    chk("R5 no self exit", failsafe, 1);
    write_src(1'b0, 1'b1);
    chk("R5 exit by write", failsafe, 0);
    chk("R7 same-cycle clear ignored", fail_flag, 1);
    chk("R9 sel after exit", sys_clk_sel, 0);
    cyc(20);
    chk("R3 stays clear", failsafe, 0);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R7 flag cleared", fail_flag, 0);

    // R9: source select bit
    write_src(1'b1, 1'b0);
    chk("R9 sel forced", sys_clk_sel, 1);
    chk("R9 no failsafe", failsafe, 0);
    write_src(1'b0, 1'b0);
    chk("R9 sel back", sys_clk_sel, 0);

    // R8: stopped clock while sleeping is not reported
    ext_en = 1'b0;
    pulse_sleep();
    cyc(40);
    chk("R8 sleep quiet", failsafe, 0);
    chk("R8 sleep flag", fail_flag, 0);
    ext_en = 1'b1;
    cyc(15);
    pulse_wake();
    cyc(20);
    chk("R2 stable after wake", osc_stable, 1);
    chk("R3 after wake", failsafe, 0);

    // R5: sleep entry ends fail-safe
    ext_en = 1'b0;
    cyc(TMO + 12);
    chk("R3 second failure", failsafe, 1);
    pulse_sleep();
    chk("R5 exit by sleep", failsafe, 0);
    chk("R7 flag survives sleep", fail_flag, 1);
    ext_en = 1'b1;
    cyc(15);
    pulse_wake();
    cyc(5);

    // R5 / R10: reset ends fail-safe
    ext_en = 1'b0;
    cyc(TMO + 12);
    chk("R3 third failure", failsafe, 1);
    ext_en = 1'b1;
    @(negedge smp_clk);
    rst_n = 1'b0;
    cyc(1);
    chk("R5 exit by reset", failsafe, 0);
    chk("R10 flag reset", fail_flag, 0);
    rst_n = 1'b1;

    // R8 / R1: crystal mode with dead clock stays in warm-up
    ext_en = 1'b0;
    do_reset(3'd1);
    cyc(600);
    chk("R8 warm-up quiet", failsafe, 0);
    chk("R1 dead stable", osc_stable, 0);
    chk("R1 dead sel", sys_clk_sel, 1);

    // R1: wake-up restarts the start-up timer
    ext_en = 1'b1;
    do_reset(3'd1);
    cyc(450);
    chk("R1 stable before sleep", osc_stable, 1);
    pulse_sleep();
    cyc(10);
    pulse_wake();
    cyc(50);
    chk("R1 rewarm stable", osc_stable, 0);
    chk("R1 rewarm sel", sys_clk_sel, 1);
    cyc(450);
    chk("R1 rewarm done", osc_stable, 1);
    chk("R1 rewarm sel ext", sys_clk_sel, 0);
    chk("R3 rewarm quiet", failsafe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule